// File: doc/BRIEF.md
# Bridge Address Window Router

This block decides where a host cycle goes. For each address and cycle type (memory or I/O) it picks one of three destinations: main memory, the primary PCI bus or the secondary graphics bus. The decision is purely combinational and comes from the current address, three programmable inclusive base/limit windows and a small set of fixed legacy regions. A registered system-management RAM (SMRAM) control byte can reclaim the legacy video range for main memory.

The I/O window compares address bits 15:12 against bits 7:4 of the I/O base and limit bytes, which gives 4 KB granularity. The two memory windows, one non-prefetchable and one prefetchable, compare address bits 31:20 against bits 15:4 of their 16-bit base and limit inputs, which gives 1 MB granularity. Fixed regions take priority over the windows. The bottom 512 KB always belongs to main memory. The video range A0000h–BFFFFh is routed by the SMRAM state, the monochrome override and the VGA forwarding enable, in that order.

The SMRAM control byte is written through `smc_wr`/`smc_wdata`. Its fields are: bits 2:0 segment code, bit 3 global enable, bit 4 close, bit 5 open, bit 6 lock. Once lock is set, the global enable, open and segment fields stay frozen until reset.

Top module: `addr_window_router`

## Requirements
- R1: `dest` is always one-hot. Bit 0 selects main memory, bit 1 the primary bus and bit 2 the secondary bus.
- R2: An I/O cycle whose address has bits 31:16 equal to zero and satisfies io_base[7:4] ≤ addr[15:12] ≤ io_limit[7:4] goes to the secondary bus with `hit`=1. Both ends of the window are included.
- R3: An I/O cycle outside the I/O window goes to the primary bus with `hit`=0.
- R4: A memory cycle with mem_base[15:4] ≤ addr[31:20] ≤ mem_limit[15:4] goes to the secondary bus with `hit`=1. Both ends are included.
- R5: The prefetchable window pf_base/pf_limit follows the same inclusive rule and routing as R4.
- R6: Memory addresses 00000h–7FFFFh always go to main memory with `hit`=1, even when a window covers them.
- R7: Outside SMRAM, A0000h–BFFFFh goes to the secondary bus when `vga_fwd`=1 and to the primary bus otherwise, with `hit`=1.
- R8: With `vga_fwd`=1 and `mono_en`=1, B0000h–B7FFFh goes to the primary bus, while the rest of the video range stays on the secondary bus.
- R9: With global enable=1 and segment code 010b, A0000h–BFFFFh goes to main memory when open=1, or when `in_smm`=1 and close=0. Otherwise it follows R7/R8.
- R10: With global enable=0 or a segment code other than 010b, the open, close and `in_smm` settings have no effect on routing.
- R11: Lock is set by a write with lock=1 and global enable=1. Afterwards, writes cannot change global enable, open or the segment code, and lock stays set until reset. Close remains writable.
- R12: A memory address that matches no rule goes to the primary bus with `hit`=0.
- R13: After reset, all SMRAM control fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the SMRAM control register |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Host cycle address |
| is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| io_base | input | 8 | I/O window base, bits 7:4 used |
| io_limit | input | 8 | I/O window limit, bits 7:4 used |
| mem_base | input | 16 | Non-prefetchable window base, bits 15:4 used |
| mem_limit | input | 16 | Non-prefetchable window limit, bits 15:4 used |
| pf_base | input | 16 | Prefetchable window base, bits 15:4 used |
| pf_limit | input | 16 | Prefetchable window limit, bits 15:4 used |
| vga_fwd | input | 1 | Send the video range to the secondary bus |
| mono_en | input | 1 | Keep B0000h–B7FFFh on the primary bus |
| in_smm | input | 1 | Host is in system-management mode |
| smc_wr | input | 1 | Write strobe for the SMRAM control byte |
| smc_wdata | input | 8 | SMRAM control write data |
| dest | output | 3 | One-hot destination {secondary, primary, memory} |
| hit | output | 1 | A window or a fixed region matched |

## Verification
The windows are probed exactly at their base and limit, and one 4 KB or 1 MB step beyond each end. This separates inclusive from exclusive compares and shows whether the correct address bits are used. A window that covers the bottom of memory checks that the 512 KB region wins over the windows. The video range is visited at A0000h, B0000h, B7FFFh and B8000h under each combination of VGA forwarding, the monochrome override and the SMRAM settings, which shows the order of the overrides. Write sequences before and after lock, followed by a reset, show which control fields freeze and when they are cleared.

// File: rtl/addr_window_router.sv
module addr_window_router (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr,
  input  logic        is_io,
  input  logic [7:0]  io_base,
  input  logic [7:0]  io_limit,
  input  logic [15:0] mem_base,
  input  logic [15:0] mem_limit,
  input  logic [15:0] pf_base,
  input  logic [15:0] pf_limit,
  input  logic        vga_fwd,
  input  logic        mono_en,
  input  logic        in_smm,
  input  logic        smc_wr,
  input  logic [7:0]  smc_wdata,
  output logic [2:0]  dest,
  output logic        hit
);
  localparam logic [2:0] TO_MEM = 3'b001;
  localparam logic [2:0] TO_PRI = 3'b010;
  localparam logic [2:0] TO_SEC = 3'b100;
  localparam logic [2:0] SMRAM_SEG = 3'b010;

  logic [2:0] seg_q;
  logic       gen_q, close_q, open_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q   <= '0;
      gen_q   <= 1'b0;
      close_q <= 1'b0;
      open_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else if (smc_wr) begin
      close_q <= smc_wdata[4];
      if (!lock_q) begin
        seg_q  <= smc_wdata[2:0];
        gen_q  <= smc_wdata[3];
        open_q <= smc_wdata[5];
        lock_q <= smc_wdata[6] & smc_wdata[3];
      end
    end
  end

  wire io_win  = (addr[31:16] == 16'h0) &&
                 (addr[15:12] >= io_base[7:4]) && (addr[15:12] <= io_limit[7:4]);
  wire mem_win = (addr[31:20] >= mem_base[15:4]) && (addr[31:20] <= mem_limit[15:4]);
  wire pf_win  = (addr[31:20] >= pf_base[15:4])  && (addr[31:20] <= pf_limit[15:4]);
  wire low_reg = (addr[31:19] == 13'h0);
  wire vga_reg = (addr[31:17] == 15'h0005);
  wire mda_reg = (addr[31:15] == 17'h00016);
  wire smram_on = gen_q && (seg_q == SMRAM_SEG) && (open_q || (in_smm && !close_q));

  always_comb begin
    dest = TO_PRI;
    hit  = 1'b1;
    if (is_io) begin
      if (io_win) dest = TO_SEC;
      else        hit  = 1'b0;
    end else if (low_reg) begin
      dest = TO_MEM;
    end else if (vga_reg) begin
      if (smram_on)                dest = TO_MEM;
      else if (mono_en && mda_reg) dest = TO_PRI;
      else if (vga_fwd)            dest = TO_SEC;
      else                         dest = TO_PRI;
    end else if (mem_win || pf_win) begin
      dest = TO_SEC;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/addr_window_router_checks.sv
module addr_window_router_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] addr,
  input logic        is_io,
  input logic [2:0]  dest,
  input logic        hit,
  input logic        lock_q,
  input logic        gen_q,
  input logic        open_q,
  input logic [2:0]  seg_q
);
  assert_dest_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dest) == 1);

  assert_io_hit_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io && hit) |-> (dest == 3'b100));

  assert_low_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_io && addr < 32'h0008_0000) |-> (dest == 3'b001 && hit));

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);

  assert_lock_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> ($stable(gen_q) && $stable(open_q) && $stable(seg_q)));

  assert_miss_primary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (dest == 3'b010));
endmodule

bind addr_window_router addr_window_router_checks u_checks (
  .clk(clk), .rst_n(rst_n), .addr(addr), .is_io(is_io), .dest(dest), .hit(hit),
  .lock_q(lock_q), .gen_q(gen_q), .open_q(open_q), .seg_q(seg_q)
);

// File: tb/addr_window_router_test.sv
module addr_window_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] addr = 0;
  logic        is_io = 0;
  logic [7:0]  io_base = 8'h20, io_limit = 8'h30;
  logic [15:0] mem_base = 16'hE000, mem_limit = 16'hE010;
  logic [15:0] pf_base = 16'hD000, pf_limit = 16'hD000;
  logic        vga_fwd = 0, mono_en = 0, in_smm = 0;
  logic        smc_wr = 0;
  logic [7:0]  smc_wdata = 0;
  logic [2:0]  dest;
  logic        hit;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [2:0] MEM = 3'b001, PRI = 3'b010, SEC = 3'b100;

  addr_window_router uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_io(is_io),
    .io_base(io_base), .io_limit(io_limit), .mem_base(mem_base), .mem_limit(mem_limit),
    .pf_base(pf_base), .pf_limit(pf_limit), .vga_fwd(vga_fwd), .mono_en(mono_en),
    .in_smm(in_smm), .smc_wr(smc_wr), .smc_wdata(smc_wdata), .dest(dest), .hit(hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic probe(input string req, input logic io, input logic [31:0] a,
                       input logic [2:0] exp_d, input logic exp_h);
    is_io = io;
    addr  = a;
    #1;
    n_run++;
    if (dest !== exp_d || hit !== exp_h) begin
      n_fail++;
      $display("FAIL %s addr=%h io=%0b: dest=%b hit=%b expected dest=%b hit=%b",
               req, a, io, dest, hit, exp_d, exp_h);
    end
  endtask

  task automatic smc_write(input logic [7:0] d);
    @(negedge clk);
    smc_wr = 1; smc_wdata = d;
    @(negedge clk);
    smc_wr = 0;
  endtask

  task automatic test_reset;
    vga_fwd = 1; in_smm = 1;
    probe("R13", 0, 32'h000A_0000, SEC, 1);
    vga_fwd = 0; in_smm = 0;
  endtask

  task automatic test_io;
    probe("R2", 1, 32'h0000_2000, SEC, 1);
    probe("R2", 1, 32'h0000_3FFF, SEC, 1);
    probe("R3", 1, 32'h0000_1FFF, PRI, 0);
    probe("R3", 1, 32'h0000_4000, PRI, 0);
    probe("R3", 1, 32'h0001_2000, PRI, 0);
    probe("R1", 1, 32'h0000_2800, SEC, 1);
  endtask

  task automatic test_mem_windows;
    probe("R4", 0, 32'hE000_0000, SEC, 1);
    probe("R4", 0, 32'hE01F_FFFF, SEC, 1);
    probe("R4", 0, 32'hE020_0000, PRI, 0);
    probe("R4", 0, 32'hDFFF_FFFF, PRI, 0);
    probe("R5", 0, 32'hD000_0000, SEC, 1);
    probe("R5", 0, 32'hD00F_FFFF, SEC, 1);
    probe("R5", 0, 32'hD010_0000, PRI, 0);
    probe("R12", 0, 32'h4000_0000, PRI, 0);
    probe("R12", 0, 32'h000C_0000, PRI, 0);
  endtask

  task automatic test_low;
    mem_base = 16'h0000; mem_limit = 16'h0000;
    probe("R6", 0, 32'h0000_0000, MEM, 1);
    probe("R6", 0, 32'h0007_FFFF, MEM, 1);
    probe("R6", 0, 32'h0008_0000, SEC, 1);
    mem_base = 16'hE000; mem_limit = 16'hE010;
  endtask

  task automatic test_vga;
    vga_fwd = 0;
    probe("R7", 0, 32'h000A_0000, PRI, 1);
    vga_fwd = 1;
    probe("R7", 0, 32'h000B_FFFF, SEC, 1);
    probe("R7", 0, 32'h000B_0000, SEC, 1);
    mono_en = 1;
    probe("R8", 0, 32'h000B_0000, PRI, 1);
    probe("R8", 0, 32'h000B_7FFF, PRI, 1);
    probe("R8", 0, 32'h000B_8000, SEC, 1);
    probe("R8", 0, 32'h000A_FFFF, SEC, 1);
    mono_en = 0;
  endtask

  task automatic test_smram;
    vga_fwd = 1;
    smc_write(8'h2A);
    probe("R9", 0, 32'h000A_0000, MEM, 1);
    probe("R9", 0, 32'h000B_FFFF, MEM, 1);
    smc_write(8'h0A);
    probe("R9", 0, 32'h000A_0000, SEC, 1);
    in_smm = 1;
    probe("R9", 0, 32'h000A_0000, MEM, 1);
    smc_write(8'h1A);
    probe("R9", 0, 32'h000A_0000, SEC, 1);
    smc_write(8'h33);
    probe("R10", 0, 32'h000A_0000, SEC, 1);
    smc_write(8'h22);
    probe("R10", 0, 32'h000A_0000, SEC, 1);
    in_smm = 0;
  endtask

  task automatic test_lock;
    vga_fwd = 1;
    smc_write(8'h6A);
    probe("R11", 0, 32'h000A_0000, MEM, 1);
    smc_write(8'h00);
    probe("R11", 0, 32'h000A_0000, MEM, 1);
    smc_write(8'h10);
    probe("R11", 0, 32'h000B_0000, MEM, 1);
    rst_n = 0;
    #1;
    probe("R13", 0, 32'h000A_0000, SEC, 1);
    @(negedge clk);
    rst_n = 1;
    smc_write(8'h40);
    smc_write(8'h2A);
    probe("R11", 0, 32'h000A_0000, MEM, 1);
    smc_write(8'h00);
    probe("R11", 0, 32'h000A_0000, SEC, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1;
    @(negedge clk);
    test_io;
    test_mem_windows;
    test_low;
    test_vga;
    test_smram;
    test_lock;
    finish_run;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run;
  end
endmodule